// File: doc/BRIEF.md
# Thread Block Dispatcher with Resource Accounting

This block takes one grid launch at a time and hands its thread blocks out to a small set of multiprocessors. Each multiprocessor has three budgets: registers, shared memory and warp slots. A launch carries the number of blocks, the threads in each block, the registers each thread needs and the shared memory each block needs. The block checks that request once when it accepts the launch. A block that could never fit on a single multiprocessor makes the launch fail.

While a launch runs, the dispatcher offers one block per clock on a valid/ready output. Block numbers count up from zero. Each block goes to the lowest-numbered multiprocessor that still has enough of all three budgets left. A multiprocessor can hold several blocks at once until one of its budgets runs out. When a multiprocessor reports that a block has finished, that block's share is returned and a waiting block can go there. Each dispatch also reports the number of warps in the block and the starting lane mask of its last warp.

Top module: `blk_dispatch`

## Requirements
- R1: After reset, launch_ready is 1, and disp_valid, launch_err and launch_done are all 0.
- R2: A launch is accepted in a cycle where launch_valid and launch_ready are both 1. The launch is rejected if any of these holds: the thread count is 0, the block count is 0, threads×registers-per-thread exceeds REG_CAP, shared memory exceeds SMEM_CAP, or ceil(threads/32) exceeds WARP_CAP. On rejection, launch_err is 1 for exactly the one cycle after acceptance, no block is dispatched, and launch_ready stays 1.
- R3: Block IDs of an accepted launch start at 0 and rise by one with each handshake (disp_valid and disp_ready both 1). disp_valid drops once every block has been handed out.
- R4: Each block goes to the lowest-numbered multiprocessor whose free registers, free shared memory and free warp slots all cover the block's need. disp_valid is 0 while no multiprocessor fits.
- R5: One multiprocessor holds several blocks at once, up to the count its budgets allow.
- R6: A done_valid pulse naming a multiprocessor that holds at least one block returns one block's resources, and a waiting block can then be dispatched there. A done_valid pulse naming a multiprocessor that holds no block is ignored.
- R7: disp_warps equals ceil(threads/32). Warps hold consecutive thread IDs, and thread 0 is in warp 0.
- R8: In disp_last_mask, bit k is 1 exactly when k < threads − 32×(warps−1). All 32 bits are 1 when the thread count is a multiple of 32.
- R9: Once all blocks have been dispatched and all have completed, launch_done is 1 for exactly one cycle, and launch_ready returns to 1 in that same cycle.
- R10: While disp_valid is 1 and disp_ready is 0, disp_valid stays 1 and disp_block_id does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | A launch request is present |
| launch_ready | output | 1 | Idle; a launch can be accepted |
| launch_blocks | input | BID_W | Number of blocks in the grid |
| launch_threads | input | THR_W | Threads per block |
| launch_regs | input | RPT_W | Registers per thread |
| launch_smem | input | SMEM_W | Shared memory per block |
| launch_err | output | 1 | One-cycle pulse: launch rejected |
| launch_done | output | 1 | One-cycle pulse: every block dispatched and completed |
| disp_valid | output | 1 | A block is offered |
| disp_ready | input | 1 | The receiver takes the offered block |
| disp_block_id | output | BID_W | ID of the offered block |
| disp_mp | output | MP_W | Multiprocessor chosen for the block |
| disp_warps | output | THR_W-4 | Number of warps in the block |
| disp_last_mask | output | 32 | Starting lane mask of the last warp |
| done_valid | input | 1 | A block has finished |
| done_mp | input | MP_W | Multiprocessor the finished block ran on |

## Verification
The bench drives inputs one time unit after a rising edge and samples at the next falling edge.

- **Dispatch fields:** disp_valid, the block ID, the chosen multiprocessor, the warp count and the mask come from registered state through combinational logic. They are therefore checked at the falling edge of the first cycle after launch acceptance, of each handshake and of each completion.
- **launch_err:** it is registered, so it is checked one edge after acceptance.
- **launch_done:** it needs one edge for the outstanding count to reach zero and a second edge for the pulse. The bench checks that it is still 0 after the first edge, 1 after the second, and 0 again after the third.

// File: rtl/blk_dispatch_pkg.sv
package blk_dispatch_pkg;

  localparam int LANES = 32;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } disp_state_e;

  // warps needed to hold a block of thr threads
  function automatic int unsigned warps_for(int unsigned thr);
    return (thr + LANES - 1) / LANES;
  endfunction

  // registers consumed by one block
  function automatic int unsigned regs_for(int unsigned thr, int unsigned rpt);
    return thr * rpt;
  endfunction

  // lanes active at start in the final warp of a block
  function automatic logic [LANES-1:0] tail_mask(int unsigned thr);
    int unsigned rem;
    logic [LANES-1:0] m;
    rem = thr % LANES;
    m = '1;
    if (rem != 0) m = ~({LANES{1'b1}} << rem);
    return m;
  endfunction

endpackage

// File: rtl/blk_dispatch_ledger.sv
module blk_dispatch_ledger #(
  parameter int REG_CAP  = 2048,
  parameter int SMEM_CAP = 8192,
  parameter int WARP_CAP = 8,
  localparam int RW = $clog2(REG_CAP + 1),
  localparam int SW = $clog2(SMEM_CAP + 1),
  localparam int WW = $clog2(WARP_CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] need_regs,
  input  logic [SW-1:0] need_smem,
  input  logic [WW-1:0] need_warps,
  input  logic          take,
  input  logic          give,
  output logic          fits,
  output logic          rel
);

  logic [RW-1:0] free_regs;
  logic [SW-1:0] free_smem;
  logic [WW-1:0] free_warps;
  logic [WW-1:0] resident;

  assign rel  = give && (resident != '0);
  assign fits = (free_regs >= need_regs) && (free_smem >= need_smem) &&
                (free_warps >= need_warps);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_regs  <= RW'(REG_CAP);
      free_smem  <= SW'(SMEM_CAP);
      free_warps <= WW'(WARP_CAP);
      resident   <= '0;
    end else begin
      free_regs  <= free_regs - (take ? need_regs : '0) + (rel ? need_regs : '0);
      free_smem  <= free_smem - (take ? need_smem : '0) + (rel ? need_smem : '0);
      free_warps <= free_warps - (take ? need_warps : '0) + (rel ? need_warps : '0);
      resident   <= resident + WW'(take) - WW'(rel);
    end
  end

endmodule

// File: rtl/blk_dispatch_pick.sv
module blk_dispatch_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch
  import blk_dispatch_pkg::*;
#(
  parameter int NUM_MP   = 4,
  parameter int REG_CAP  = 2048,
  parameter int SMEM_CAP = 8192,
  parameter int WARP_CAP = 8,
  parameter int BID_W    = 12,
  parameter int THR_W    = 10,
  parameter int RPT_W    = 8,
  parameter int SMEM_W   = 16,
  localparam int MP_W    = (NUM_MP > 1) ? $clog2(NUM_MP) : 1,
  localparam int WOUT_W  = THR_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  output logic              launch_ready,
  input  logic [BID_W-1:0]  launch_blocks,
  input  logic [THR_W-1:0]  launch_threads,
  input  logic [RPT_W-1:0]  launch_regs,
  input  logic [SMEM_W-1:0] launch_smem,
  output logic              launch_err,
  output logic              launch_done,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [BID_W-1:0]  disp_block_id,
  output logic [MP_W-1:0]   disp_mp,
  output logic [WOUT_W-1:0] disp_warps,
  output logic [31:0]       disp_last_mask,
  input  logic              done_valid,
  input  logic [MP_W-1:0]   done_mp
);

  localparam int RW = $clog2(REG_CAP + 1);
  localparam int SW = $clog2(SMEM_CAP + 1);
  localparam int WW = $clog2(WARP_CAP + 1);

  disp_state_e state;

  // request evaluation at the launch port
  int unsigned req_regs;
  int unsigned req_warps;
  logic        launch_bad;
  logic        launch_take;

  assign req_regs   = regs_for(int'(launch_threads), int'(launch_regs));
  assign req_warps  = warps_for(int'(launch_threads));
  assign launch_bad = (launch_threads == '0) || (launch_blocks == '0) ||
                      (req_regs > REG_CAP) || (int'(launch_smem) > SMEM_CAP) ||
                      (req_warps > WARP_CAP);
  assign launch_take = launch_valid && (state == ST_IDLE);
  assign launch_ready = (state == ST_IDLE);

  // latched job
  logic [BID_W-1:0]  job_blocks;
  logic [RW-1:0]     job_regs;
  logic [SW-1:0]     job_smem;
  logic [WW-1:0]     job_warps;
  logic [WOUT_W-1:0] job_wout;
  logic [31:0]       job_mask;
  logic [BID_W-1:0]  next_id;
  logic [BID_W-1:0]  outstanding;

  // named internal events
  logic [NUM_MP-1:0] fits_vec;
  logic [NUM_MP-1:0] take_vec;
  logic [NUM_MP-1:0] rel_vec;
  logic [MP_W-1:0]   pick_idx;
  logic              pick_any;
  logic              all_issued;
  logic              disp_fire;
  logic              rel_any;
  logic              done_cond;

  blk_dispatch_pick #(.N(NUM_MP), .IW(MP_W)) u_pick (
    .req (fits_vec),
    .idx (pick_idx),
    .any (pick_any)
  );

  for (genvar g = 0; g < NUM_MP; g++) begin : g_mp
    assign take_vec[g] = disp_fire && (pick_idx == MP_W'(g));
    blk_dispatch_ledger #(
      .REG_CAP (REG_CAP),
      .SMEM_CAP(SMEM_CAP),
      .WARP_CAP(WARP_CAP)
    ) u_ledger (
      .clk        (clk),
      .rst_n      (rst_n),
      .need_regs  (job_regs),
      .need_smem  (job_smem),
      .need_warps (job_warps),
      .take       (take_vec[g]),
      .give       (done_valid && (done_mp == MP_W'(g))),
      .fits       (fits_vec[g]),
      .rel        (rel_vec[g])
    );
  end

  assign all_issued = (next_id == job_blocks);
  assign disp_valid = (state == ST_RUN) && !all_issued && pick_any;
  assign disp_fire  = disp_valid && disp_ready;
  assign rel_any    = |rel_vec;
  assign done_cond  = (state == ST_RUN) && all_issued && (outstanding == '0);

  assign disp_block_id  = next_id;
  assign disp_mp        = pick_idx;
  assign disp_warps     = job_wout;
  assign disp_last_mask = job_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      launch_err  <= 1'b0;
      launch_done <= 1'b0;
      job_blocks  <= '0;
      job_regs    <= '0;
      job_smem    <= '0;
      job_warps   <= '0;
      job_wout    <= '0;
      job_mask    <= '0;
      next_id     <= '0;
      outstanding <= '0;
    end else begin
      launch_err  <= launch_take && launch_bad;
      launch_done <= done_cond;
      if (launch_take && !launch_bad) begin
        state      <= ST_RUN;
        job_blocks <= launch_blocks;
        job_regs   <= RW'(req_regs);
        job_smem   <= SW'(launch_smem);
        job_warps  <= WW'(req_warps);
        job_wout   <= WOUT_W'(req_warps);
        job_mask   <= tail_mask(int'(launch_threads));
        next_id    <= '0;
      end else if (done_cond) begin
        state <= ST_IDLE;
      end else if (disp_fire) begin
        next_id <= next_id + 1'b1;
      end
      outstanding <= outstanding + BID_W'(disp_fire) - BID_W'(rel_any);
    end
  end

endmodule

// File: rtl/blk_dispatch_checker.sv
module blk_dispatch_checker #(
  parameter int NUM_MP = 4,
  parameter int BID_W  = 12,
  localparam int MP_W  = (NUM_MP > 1) ? $clog2(NUM_MP) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [BID_W-1:0]  disp_block_id,
  input logic [MP_W-1:0]   disp_mp,
  input logic [31:0]       disp_last_mask,
  input logic              launch_err,
  input logic              launch_done,
  input logic              launch_ready,
  input logic [NUM_MP-1:0] fits_vec
);

  logic [NUM_MP-1:0] below_mask;
  always_comb below_mask = (NUM_MP'(1) << disp_mp) - NUM_MP'(1);

  p_pick_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> fits_vec[disp_mp]);

  p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ((fits_vec & below_mask) == '0));

  p_id_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> (disp_block_id == $past(disp_block_id) + 1'b1));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_block_id)));

  p_lane0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> disp_last_mask[0]);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    launch_done |=> !launch_done);

  p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_err |-> (!disp_valid && launch_ready && !launch_done));

endmodule

bind blk_dispatch blk_dispatch_checker #(
  .NUM_MP(NUM_MP),
  .BID_W (BID_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .disp_valid     (disp_valid),
  .disp_ready     (disp_ready),
  .disp_block_id  (disp_block_id),
  .disp_mp        (disp_mp),
  .disp_last_mask (disp_last_mask),
  .launch_err     (launch_err),
  .launch_done    (launch_done),
  .launch_ready   (launch_ready),
  .fits_vec       (fits_vec)
);

// File: tb/blk_dispatch_bench.sv
`timescale 1ns/1ps
module blk_dispatch_bench;

  localparam int NMP  = 4;
  localparam int RCAP = 2048;
  localparam int SCAP = 8192;
  localparam int WCAP = 8;
  localparam int NV   = 10;

  // threads, regs/thread, smem, blocks, expect_err
  localparam int VEC [NV][5] = '{
    '{64, 8, 1024, 5, 0},
    '{40, 16, 0, 3, 0},
    '{33, 4, 100, 4, 0},
    '{256, 8, 0, 4, 0},
    '{1, 1, 8192, 2, 0},
    '{257, 1, 0, 1, 1},
    '{32, 65, 0, 1, 1},
    '{32, 1, 8193, 1, 1},
    '{0, 1, 0, 1, 1},
    '{32, 1, 0, 0, 1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch_valid = 1'b0;
  logic        launch_ready;
  logic [11:0] launch_blocks = '0;
  logic [9:0]  launch_threads = '0;
  logic [7:0]  launch_regs = '0;
  logic [15:0] launch_smem = '0;
  logic        launch_err;
  logic        launch_done;
  logic        disp_valid;
  logic        disp_ready = 1'b0;
  logic [11:0] disp_block_id;
  logic [1:0]  disp_mp;
  logic [5:0]  disp_warps;
  logic [31:0] disp_last_mask;
  logic        done_valid = 1'b0;
  logic [1:0]  done_mp = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int per_mp;

  always #4 clk = ~clk;

  blk_dispatch u_blk_dispatch (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_blocks(launch_blocks), .launch_threads(launch_threads),
    .launch_regs(launch_regs), .launch_smem(launch_smem),
    .launch_err(launch_err), .launch_done(launch_done),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_block_id(disp_block_id), .disp_mp(disp_mp),
    .disp_warps(disp_warps), .disp_last_mask(disp_last_mask),
    .done_valid(done_valid), .done_mp(done_mp)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int exp_warps(int thr);
    return thr / 32 + ((thr % 32) != 0 ? 1 : 0);
  endfunction

  function automatic logic [31:0] exp_mask(int thr);
    logic [31:0] m;
    int live;
    live = thr - 32 * (exp_warps(thr) - 1);
    for (int k = 0; k < 32; k++) m[k] = (k < live);
    return m;
  endfunction

  function automatic int blocks_per_mp(int thr, int rpt, int sm);
    int c;
    c = WCAP / exp_warps(thr);
    if (RCAP / (thr * rpt) < c) c = RCAP / (thr * rpt);
    if (sm != 0 && SCAP / sm < c) c = SCAP / sm;
    return c;
  endfunction

  task automatic do_launch(input int thr, input int rpt, input int sm, input int nb);
    launch_threads = 10'(thr);
    launch_regs    = 8'(rpt);
    launch_smem    = 16'(sm);
    launch_blocks  = 12'(nb);
    launch_valid   = 1'b1;
    tick();
    launch_valid   = 1'b0;
  endtask

  task automatic complete(input int mp);
    done_valid = 1'b1;
    done_mp    = 2'(mp);
    tick();
    done_valid = 1'b0;
  endtask

  // after last completion edge: pulse due one edge later
  task automatic expect_done();
    @(negedge clk);
    chk("R9 launch_done early", launch_done, 0);
    tick();
    @(negedge clk);
    chk("R9 launch_done pulse", launch_done, 1);
    chk("R9 ready with done", launch_ready, 1);
    tick();
    @(negedge clk);
    chk("R9 launch_done one cycle", launch_done, 0);
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) tick();
    @(negedge clk);
    chk("R1 ready in reset", launch_ready, 1);
    chk("R1 valid in reset", disp_valid, 0);
    rst_n = 1'b1;
    tick();
    @(negedge clk);
    chk("R1 ready", launch_ready, 1);
    chk("R1 disp_valid", disp_valid, 0);
    chk("R1 launch_err", launch_err, 0);
    chk("R1 launch_done", launch_done, 0);
    tick();

    // vector table
    for (int v = 0; v < NV; v++) begin
      do_launch(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      @(negedge clk);
      chk("R2 launch_err", launch_err, 64'(VEC[v][4]));
      if (VEC[v][4] != 0) begin
        chk("R2 ready after reject", launch_ready, 1);
        chk("R2 no dispatch", disp_valid, 0);
        tick();
        @(negedge clk);
        chk("R2 err one cycle", launch_err, 0);
        tick();
      end else begin
        per_mp = blocks_per_mp(VEC[v][0], VEC[v][1], VEC[v][2]);
        disp_ready = 1'b1;
        for (int k = 0; k < VEC[v][3]; k++) begin
          if (k > 0) @(negedge clk);
          chk("R3 valid", disp_valid, 1);
          chk("R3 block id", disp_block_id, 64'(k));
          chk("R4 R5 mp choice", disp_mp, 64'(k / per_mp));
          chk("R7 warps", disp_warps, 64'(exp_warps(VEC[v][0])));
          chk("R8 last mask", disp_last_mask, exp_mask(VEC[v][0]));
          tick();
        end
        disp_ready = 1'b0;
        @(negedge clk);
        chk("R3 valid drops", disp_valid, 0);
        for (int k = 0; k < VEC[v][3]; k++) complete(k / per_mp);
        expect_done();
      end
    end

    // backpressure, full machine, refill
    do_launch(256, 8, 0, 6);
    @(negedge clk);
    chk("R10 offered", disp_valid, 1);
    tick();
    tick();
    @(negedge clk);
    chk("R10 still valid", disp_valid, 1);
    chk("R10 id held", disp_block_id, 0);
    disp_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      chk("R4 spread id", disp_block_id, 64'(k));
      chk("R4 spread mp", disp_mp, 64'(k));
      tick();
    end
    @(negedge clk);
    chk("R4 none fits", disp_valid, 0);
    complete(2);
    @(negedge clk);
    chk("R6 refill valid", disp_valid, 1);
    chk("R6 refill mp", disp_mp, 2);
    chk("R6 refill id", disp_block_id, 4);
    tick();
    @(negedge clk);
    chk("R4 full again", disp_valid, 0);
    complete(0);
    @(negedge clk);
    chk("R6 refill mp0", disp_mp, 0);
    chk("R6 refill id5", disp_block_id, 5);
    tick();
    disp_ready = 1'b0;
    for (int m = 0; m < 4; m++) complete(m);
    expect_done();

    // completion on an empty multiprocessor is ignored
    do_launch(32, 1, 0, 1);
    disp_ready = 1'b1;
    @(negedge clk);
    chk("R6 single mp", disp_mp, 0);
    tick();
    disp_ready = 1'b0;
    complete(3);
    @(negedge clk);
    chk("R6 ignored no done", launch_done, 0);
    tick();
    @(negedge clk);
    chk("R6 ignored still no done", launch_done, 0);
    chk("R6 ignored still busy", launch_ready, 0);
    tick();
    complete(0);
    expect_done();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule